// File: doc/BRIEF.md
# Byte FIFO with Variable-Width Host Port and Watermark Data Request

This block is the data buffer of an I2C master engine. One byte queue serves both directions. During a write command the host fills it and the bit engine drains it. During a read command the bit engine fills it and the host drains it. The host side sits behind one 32-bit data register. Each access moves one, two or four bytes, selected by a size code. The bit engine side is a plain single-byte push/pop port.

The block reports its fill count and its fixed capacity. It compares the count against a programmable high mark and a programmable low mark. From those comparisons and the direction of the current command, it raises a data-request line that tells the host when to service the queue. A byte that arrives while the queue is full is discarded and sets a sticky overrun flag. An engine reset empties the queue and clears that flag.

Top module: `wmf_fifo_top`

## Requirements
- R1: After reset `fill_count` is 0, `overrun` is 0 and `data_req` is 0. `capacity` always equals the DEPTH parameter, which defaults to 8.
- R2: A host write with `host_size` 0, 1 or 2 pushes 1, 2 or 4 bytes respectively. The bytes are the low-order bytes of `host_wdata`, and the most significant of them is pushed first. `fill_count` rises by the number of bytes accepted.
- R3: A host read with size code 0, 1 or 2 pops 1, 2 or 4 bytes. They appear on `host_rdata` one cycle later, right-aligned in a field of that width, with the first popped byte in the field's most significant lane. Lanes for which no byte was held read as zero, and bits above the field are zero. `host_rdata` holds its value until the next read.
- R4: Engine pushes and pops move single bytes in first-in first-out order, shared with host accesses. `eng_pop_byte` shows the popped byte in the same cycle as `eng_pop`. A pop from an empty queue returns 0 and leaves the count at 0.
- R5: The count never exceeds DEPTH. When bytes arrive with no room left, they are dropped, and `overrun` is set. A host write that only partly fits keeps its leading bytes. `overrun` stays set until an engine reset.
- R6: `eng_reset` empties the queue within one cycle, bringing `fill_count` to 0 and `overrun` to 0.
- R7: `hi_mark` is 1 exactly when `fill_count` >= `wm_high`. `lo_mark` is 1 exactly when `fill_count` <= `wm_low`.
- R8: In a write command (`cmd_active`=1, `cmd_is_read`=0, `cmd_ended`=0), `data_req` equals `lo_mark`. When `cmd_active` is 0, `data_req` is 0.
- R9: In a read command (`cmd_active`=1, `cmd_is_read`=1), `data_req` is 1 when `hi_mark` is 1. It is also 1 when `cmd_ended` is 1 and the queue holds at least one byte.
- R10: Size code 3 is not a valid access. A host write or read with it changes neither the queue nor `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_reset | input | 1 | Engine reset: flush queue, clear overrun |
| host_wr_en | input | 1 | Host write to the data register |
| host_rd_en | input | 1 | Host read from the data register |
| host_size | input | 2 | Access size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=none |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_rdata | output | 32 | Host read data, registered |
| eng_push | input | 1 | Bit engine pushes one byte |
| eng_push_byte | input | 8 | Byte pushed by the bit engine |
| eng_pop | input | 1 | Bit engine pops one byte |
| eng_pop_byte | output | 8 | Byte popped by the bit engine, same cycle |
| wm_high | input | 4 | High watermark |
| wm_low | input | 4 | Low watermark |
| cmd_active | input | 1 | A command is in progress |
| cmd_is_read | input | 1 | The current command is a read |
| cmd_ended | input | 1 | The current command has ended |
| fill_count | output | 8 | Bytes held |
| capacity | output | 8 | Fixed capacity |
| hi_mark | output | 1 | Count at or above high watermark |
| lo_mark | output | 1 | Count at or below low watermark |
| data_req | output | 1 | Host should service the queue |
| overrun | output | 1 | Sticky: a byte was dropped while full |

## Verification
Lane packing is tried with writes of all three widths carrying distinct byte values. Interleaving them with engine pushes and then reading back in other widths shows whether push order, lane order and the boundary between host and engine bytes are kept. Reads that ask for more bytes than are held tell zero-filled lanes apart from stale data. Writes that only partly fit separate a correct leading-byte keep from dropping the whole access. Walking the count across both watermarks in each command direction, with and without the ended flag, separates the two request rules.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

   localparam int BUS_BYTES = 4;

   typedef enum logic [1:0] {
      SZ_ONE  = 2'd0,
      SZ_TWO  = 2'd1,
      SZ_FOUR = 2'd2,
      SZ_NONE = 2'd3
   } acc_size_e;

   function automatic logic [2:0] size_bytes(acc_size_e s);
      case (s)
         SZ_ONE:  return 3'd1;
         SZ_TWO:  return 3'd2;
         SZ_FOUR: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/wmf_lanes.sv
module wmf_lanes
   import wmf_pkg::*;
(
   input  acc_size_e                      size,
   input  logic [8*BUS_BYTES-1:0]         wdata,
   input  logic [BUS_BYTES-1:0][7:0]      pop_bytes,
   output logic [2:0]                     nbytes,
   output logic [BUS_BYTES-1:0][7:0]      push_bytes,
   output logic [8*BUS_BYTES-1:0]         rword
);

   assign nbytes = size_bytes(size);

   // Byte k of an access sits at lane (n-1-k): most significant goes first.
   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      always_comb begin
         push_bytes[k] = 8'd0;
         for (int l = 0; l < BUS_BYTES; l++) begin
            if ((k < int'(nbytes)) && (l == int'(nbytes) - 1 - k))
               push_bytes[k] = wdata[8*l +: 8];
         end
      end
   end

   always_comb begin
      rword = '0;
      for (int k = 0; k < BUS_BYTES; k++) begin
         for (int l = 0; l < BUS_BYTES; l++) begin
            if ((k < int'(nbytes)) && (l == int'(nbytes) - 1 - k))
               rword[8*l +: 8] = pop_bytes[k];
         end
      end
   end

endmodule

// File: rtl/wmf_store.sv
module wmf_store
   import wmf_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic [2:0]                    host_pop_n,
   input  logic [2:0]                    host_push_n,
   input  logic [BUS_BYTES-1:0][7:0]     host_push_bytes,
   input  logic                          eng_push,
   input  logic [7:0]                    eng_push_byte,
   input  logic                          eng_pop,
   output logic [CW-1:0]                 count,
   output logic [BUS_BYTES-1:0][7:0]     host_pop_bytes,
   output logic [7:0]                    eng_pop_byte,
   output logic                          dropped
);

   localparam int AW   = $clog2(DEPTH);
   localparam int SW   = AW + 4;
   localparam bit POW2 = ((1 << AW) == DEPTH);

   function automatic logic [AW-1:0] adv(logic [AW-1:0] p, logic [2:0] off);
      logic [SW-1:0] s;
      s = SW'(p) + SW'(off);
      if (s >= SW'(DEPTH)) s = s - SW'(DEPTH);
      return s[AW-1:0];
   endfunction

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr, rd_ptr_nx, wr_ptr_nx;
   logic [CW-1:0] cnt_q, space, room;
   logic [2:0]    host_take, ptake, host_put, wr_adv;
   logic          eng_take, eng_put;

   // Pops first (host, then engine), then pushes (engine, then host).
   always_comb begin
      host_take = (CW'(host_pop_n) <= cnt_q) ? host_pop_n : cnt_q[2:0];
      eng_take  = eng_pop && (cnt_q > CW'(host_take));
      ptake     = host_take + {2'b00, eng_take};
      space     = CW'(DEPTH) - cnt_q + CW'(ptake);
      eng_put   = eng_push && (space != '0);
      room      = space - CW'(eng_put);
      host_put  = (CW'(host_push_n) <= room) ? host_push_n : room[2:0];
      wr_adv    = host_put + {2'b00, eng_put};
      dropped   = (eng_push && !eng_put) || (host_put != host_push_n);
   end

   if (POW2) begin : g_wrap_pow2
      assign rd_ptr_nx = rd_ptr + AW'(ptake);
      assign wr_ptr_nx = wr_ptr + AW'(wr_adv);
   end else begin : g_wrap_cmp
      assign rd_ptr_nx = adv(rd_ptr, ptake);
      assign wr_ptr_nx = adv(wr_ptr, wr_adv);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         rd_ptr <= rd_ptr_nx;
         wr_ptr <= wr_ptr_nx;
         cnt_q  <= cnt_q - CW'(ptake) + CW'(wr_adv);
      end
   end

   always_ff @(posedge clk) begin
      if (!flush) begin
         if (eng_put) mem[wr_ptr] <= eng_push_byte;
         for (int k = 0; k < BUS_BYTES; k++) begin
            if (3'(k) < host_put)
               mem[adv(wr_ptr, 3'(k) + {2'b00, eng_put})] <= host_push_bytes[k];
         end
      end
   end

   always_comb begin
      for (int k = 0; k < BUS_BYTES; k++)
         host_pop_bytes[k] = (CW'(k) < cnt_q) ? mem[adv(rd_ptr, 3'(k))] : 8'd0;
      eng_pop_byte = eng_take ? mem[adv(rd_ptr, host_take)] : 8'd0;
   end

   assign count = cnt_q;

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && eng_pop && !eng_push && host_push_n == 3'd0 && !flush)
      |-> (eng_pop_byte == 8'd0) ##1 (cnt_q == '0));

endmodule

// File: rtl/wmf_mark.sv
module wmf_mark #(
   parameter int CW = 4,
   parameter int MW = 4
) (
   input  logic [CW-1:0] count,
   input  logic [MW-1:0] wm_high,
   input  logic [MW-1:0] wm_low,
   input  logic          cmd_active,
   input  logic          cmd_is_read,
   input  logic          cmd_ended,
   output logic          hi,
   output logic          lo,
   output logic          dreq
);

   always_comb begin
      hi = int'(count) >= int'(wm_high);
      lo = int'(count) <= int'(wm_low);
      if (!cmd_active)      dreq = 1'b0;
      else if (cmd_is_read) dreq = hi || (cmd_ended && count != '0);
      else                  dreq = lo && !cmd_ended;
   end

endmodule

// File: rtl/wmf_fifo_top.sv
module wmf_fifo_top
   import wmf_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int MARK_W = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        eng_reset,
   input  logic        host_wr_en,
   input  logic        host_rd_en,
   input  logic [1:0]  host_size,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   input  logic        eng_push,
   input  logic [7:0]  eng_push_byte,
   input  logic        eng_pop,
   output logic [7:0]  eng_pop_byte,
   input  logic [3:0]  wm_high,
   input  logic [3:0]  wm_low,
   input  logic        cmd_active,
   input  logic        cmd_is_read,
   input  logic        cmd_ended,
   output logic [7:0]  fill_count,
   output logic [7:0]  capacity,
   output logic        hi_mark,
   output logic        lo_mark,
   output logic        data_req,
   output logic        overrun
);

   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 8 || DEPTH > 255) begin : g_bad_depth
      $error("wmf_fifo_top: DEPTH must lie in 8..255");
   end
   if (MARK_W != 4) begin : g_bad_mark
      $error("wmf_fifo_top: MARK_W must be 4");
   end

   logic [2:0]                 nbytes, pop_n, push_n;
   logic [BUS_BYTES-1:0][7:0]  push_bytes, pop_bytes;
   logic [31:0]                rword;
   logic [CW-1:0]              cnt;
   logic                       dropped;

   wmf_lanes u_lanes (
      .size       (acc_size_e'(host_size)),
      .wdata      (host_wdata),
      .pop_bytes  (pop_bytes),
      .nbytes     (nbytes),
      .push_bytes (push_bytes),
      .rword      (rword)
   );

   assign pop_n  = host_rd_en ? nbytes : 3'd0;
   assign push_n = host_wr_en ? nbytes : 3'd0;

   wmf_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
      .clk             (clk),
      .rst_n           (rst_n),
      .flush           (eng_reset),
      .host_pop_n      (pop_n),
      .host_push_n     (push_n),
      .host_push_bytes (push_bytes),
      .eng_push        (eng_push),
      .eng_push_byte   (eng_push_byte),
      .eng_pop         (eng_pop),
      .count           (cnt),
      .host_pop_bytes  (pop_bytes),
      .eng_pop_byte    (eng_pop_byte),
      .dropped         (dropped)
   );

   wmf_mark #(.CW(CW), .MW(MARK_W)) u_mark (
      .count       (cnt),
      .wm_high     (wm_high),
      .wm_low      (wm_low),
      .cmd_active  (cmd_active),
      .cmd_is_read (cmd_is_read),
      .cmd_ended   (cmd_ended),
      .hi          (hi_mark),
      .lo          (lo_mark),
      .dreq        (data_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
         overrun    <= 1'b0;
      end else if (eng_reset) begin
         overrun    <= 1'b0;
      end else begin
         if (dropped) overrun <= 1'b1;
         if (pop_n != 3'd0) host_rdata <= rword;
      end
   end

   assign fill_count = 8'(cnt);
   assign capacity   = 8'(DEPTH);

   assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_reset |=> (fill_count == 8'd0 && !overrun));

   assert_full_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_count == capacity && eng_push && !eng_pop && !host_rd_en && !eng_reset)
      |=> overrun);

   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !eng_reset) |=> overrun);

   assert_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_size == 2'd3 && !eng_push && !eng_pop && !eng_reset)
      |=> ($stable(fill_count) && $stable(host_rdata)));

endmodule

// File: tb/wmf_fifo_top_tb_top.sv
module wmf_fifo_top_tb_top;

   typedef struct packed {
      logic [1:0]  op;      // 0 host write, 1 host read, 2 engine push, 3 engine pop
      logic [1:0]  sz;
      logic [31:0] wd;
      logic [31:0] exp_d;
      logic        chk_d;
      logic [7:0]  exp_cnt;
      logic        exp_ovr;
   } vec_t;

   localparam vec_t VECS [18] = '{
      '{2'd0, 2'd2, 32'h11223344, 32'h0,        1'b0, 8'd4, 1'b0},
      '{2'd3, 2'd0, 32'h0,        32'h11,       1'b1, 8'd3, 1'b0},
      '{2'd1, 2'd1, 32'h0,        32'h00002233, 1'b1, 8'd1, 1'b0},
      '{2'd1, 2'd2, 32'h0,        32'h44000000, 1'b1, 8'd0, 1'b0},
      '{2'd3, 2'd0, 32'h0,        32'h0,        1'b1, 8'd0, 1'b0},
      '{2'd0, 2'd0, 32'hAABBCCDD, 32'h0,        1'b0, 8'd1, 1'b0},
      '{2'd2, 2'd0, 32'h5A,       32'h0,        1'b0, 8'd2, 1'b0},
      '{2'd0, 2'd1, 32'h0000EEFF, 32'h0,        1'b0, 8'd4, 1'b0},
      '{2'd0, 2'd3, 32'h12345678, 32'h0,        1'b0, 8'd4, 1'b0},
      '{2'd1, 2'd2, 32'h0,        32'hDD5AEEFF, 1'b1, 8'd0, 1'b0},
      '{2'd0, 2'd2, 32'h01020304, 32'h0,        1'b0, 8'd4, 1'b0},
      '{2'd0, 2'd2, 32'h05060708, 32'h0,        1'b0, 8'd8, 1'b0},
      '{2'd0, 2'd0, 32'h00000099, 32'h0,        1'b0, 8'd8, 1'b1},
      '{2'd1, 2'd2, 32'h0,        32'h01020304, 1'b1, 8'd4, 1'b1},
      '{2'd1, 2'd0, 32'h0,        32'h00000005, 1'b1, 8'd3, 1'b1},
      '{2'd1, 2'd3, 32'h0,        32'h00000005, 1'b1, 8'd3, 1'b1},
      '{2'd1, 2'd1, 32'h0,        32'h00000607, 1'b1, 8'd1, 1'b1},
      '{2'd1, 2'd1, 32'h0,        32'h00000800, 1'b1, 8'd0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eng_reset = 1'b0, host_wr_en = 1'b0, host_rd_en = 1'b0;
   logic [1:0]  host_size = 2'd0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic        eng_push = 1'b0, eng_pop = 1'b0;
   logic [7:0]  eng_push_byte = '0, eng_pop_byte;
   logic [3:0]  wm_high = 4'd6, wm_low = 4'd2;
   logic        cmd_active = 1'b0, cmd_is_read = 1'b0, cmd_ended = 1'b0;
   logic [7:0]  fill_count, capacity;
   logic        hi_mark, lo_mark, data_req, overrun;

   int total = 0, bad = 0, cycles = 0;
   logic done = 1'b0;
   logic [7:0] popped;

   always #5 clk = ~clk;

   wmf_fifo_top dut_i (
      .clk, .rst_n, .eng_reset, .host_wr_en, .host_rd_en, .host_size,
      .host_wdata, .host_rdata, .eng_push, .eng_push_byte, .eng_pop,
      .eng_pop_byte, .wm_high, .wm_low, .cmd_active, .cmd_is_read,
      .cmd_ended, .fill_count, .capacity, .hi_mark, .lo_mark, .data_req,
      .overrun
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(logic [1:0] op, logic [1:0] sz, logic [31:0] wd);
      @(negedge clk);
      host_size     = sz;
      host_wdata    = wd;
      eng_push_byte = wd[7:0];
      host_wr_en    = (op == 2'd0);
      host_rd_en    = (op == 2'd1);
      eng_push      = (op == 2'd2);
      eng_pop       = (op == 2'd3);
      #1 popped = eng_pop_byte;
      @(posedge clk);
      #1;
      host_wr_en = 1'b0; host_rd_en = 1'b0; eng_push = 1'b0; eng_pop = 1'b0;
   endtask

   task automatic pulse_flush();
      @(negedge clk);
      eng_reset = 1'b1;
      @(posedge clk);
      #1 eng_reset = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<20000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 count", 32'(fill_count), 32'd0);
      check("R1 capacity", 32'(capacity), 32'd8);
      check("R1 overrun", 32'(overrun), 32'd0);
      check("R1 data_req", 32'(data_req), 32'd0);

      // Vector walk: R2 R3 R4 R5 R10
      foreach (VECS[i]) begin
         do_op(VECS[i].op, VECS[i].sz, VECS[i].wd);
         check($sformatf("R2/R3/R4/R10 vec%0d count", i), 32'(fill_count), 32'(VECS[i].exp_cnt));
         check($sformatf("R5 vec%0d overrun", i), 32'(overrun), 32'(VECS[i].exp_ovr));
         if (VECS[i].chk_d) begin
            if (VECS[i].op == 2'd3)
               check($sformatf("R4 vec%0d pop byte", i), 32'(popped), VECS[i].exp_d);
            else
               check($sformatf("R3 vec%0d rdata", i), host_rdata, VECS[i].exp_d);
         end
      end

      // R6 flush clears data and overrun
      do_op(2'd0, 2'd2, 32'hCAFEF00D);
      pulse_flush();
      check("R6 count", 32'(fill_count), 32'd0);
      check("R6 overrun", 32'(overrun), 32'd0);
      do_op(2'd3, 2'd0, 32'h0);
      check("R6 empty after flush", 32'(popped), 32'd0);

      // R5 partial write keeps leading bytes
      do_op(2'd0, 2'd2, 32'hA1A2A3A4);
      do_op(2'd0, 2'd1, 32'h0000B1B2);
      do_op(2'd0, 2'd2, 32'hC1C2C3C4);
      check("R5 partial count", 32'(fill_count), 32'd8);
      check("R5 partial overrun", 32'(overrun), 32'd1);
      do_op(2'd1, 2'd2, 32'h0);
      check("R5 first word", host_rdata, 32'hA1A2A3A4);
      do_op(2'd1, 2'd2, 32'h0);
      check("R5 kept leading bytes", host_rdata, 32'hB1B2C1C2);
      pulse_flush();

      // R7 R8 R9 watermarks and data request
      @(negedge clk);
      cmd_active = 1'b1; cmd_is_read = 1'b0; cmd_ended = 1'b0;
      #1;
      check("R7 lo at 0", 32'(lo_mark), 32'd1);
      check("R7 hi at 0", 32'(hi_mark), 32'd0);
      check("R8 write req at 0", 32'(data_req), 32'd1);
      do_op(2'd0, 2'd1, 32'h00000102);
      check("R8 write req at 2", 32'(data_req), 32'd1);
      do_op(2'd2, 2'd0, 32'h03);
      check("R7 lo at 3", 32'(lo_mark), 32'd0);
      check("R8 write no req at 3", 32'(data_req), 32'd0);
      @(negedge clk);
      cmd_is_read = 1'b1;
      #1 check("R9 read no req at 3", 32'(data_req), 32'd0);
      cmd_ended = 1'b1;
      #1 check("R9 ended with data", 32'(data_req), 32'd1);
      cmd_ended = 1'b0;
      do_op(2'd0, 2'd1, 32'h00000405);
      check("R7 hi below mark", 32'(hi_mark), 32'd0);
      do_op(2'd2, 2'd0, 32'h06);
      check("R7 hi at 6", 32'(hi_mark), 32'd1);
      check("R9 read req at high", 32'(data_req), 32'd1);
      @(negedge clk);
      cmd_active = 1'b0;
      #1 check("R8 idle no req", 32'(data_req), 32'd0);
      pulse_flush();
      @(negedge clk);
      cmd_active = 1'b1; cmd_is_read = 1'b1; cmd_ended = 1'b1;
      #1 check("R9 ended but empty", 32'(data_req), 32'd0);
      cmd_active = 1'b0;

      finish_run();
   end

endmodule